// File: doc/BRIEF.md
# Prioritised Interrupt Concentrator

This block gathers up to 79 interrupt request lines from peripherals and drives one interrupt line to a single processor. Each request line has its own small gateway. The gateway turns the raw input into a pending flag, and it can watch for rising edges or follow the input level. Software programs, per line, a two-bit priority, a forwarding enable and the trigger style. It also programs one threshold for the processor.

When the processor takes the interrupt, it reads the claim/complete word. That read returns the identifier of the best qualifying pending line and takes ownership of it. When service is finished, software writes the same identifier back to that word. A line that is owned cannot be presented again. In edge mode, edges that arrive during ownership are held and surface after the release. In level mode, the input is looked at again after the release.

Top module: `irq_hub`

## Requirements
- R1: After reset the interrupt line is low, and every register reads zero: the claim word, the source words and the threshold.
- R2: A line is presented only if it is pending, its enable bit is 1 and its priority is strictly greater than the threshold. A read of the claim word (address 0) returns the identifier (1..79) of the line that wins, or 0 when no line qualifies.
- R3: Among qualifying lines the highest priority wins. When priorities are equal, the lowest identifier wins.
- R4: In level mode (source word bit 3 = 0), a high input on an unowned line sets pending. After a release, the input is sampled again, so a line that is still high becomes pending again.
- R5: In edge mode (bit 3 = 1), a rising edge on an unowned line sets pending. A rising edge seen while the line is owned is held. This includes an edge in the same cycle as the claim. The held edge sets pending one cycle after the release. A level that stays high does not set pending again.
- R6: A claim read that returns a nonzero identifier clears that line's pending bit and marks it owned. An owned line is never returned by a claim read.
- R7: A write to address 0 of an owned identifier releases that line. A write of any other value leaves every line's ownership unchanged.
- R8: The enable bit only gates forwarding. A disabled line still becomes pending, and its pending bit can be read, while the interrupt line stays low.
- R9: The interrupt line is a register. It reflects pending, enable and threshold state one clock after that state changes.
- R10: Register map, word addressed. Address 0 is the claim/complete word. Addresses 1..79 are the source words: bits 1:0 priority, bit 2 enable, bit 3 edge mode, bit 4 pending (read only), bit 5 owned (read only). Address 0x80 is the threshold, in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC (79) | Raw request lines; bit k is identifier k+1 |
| reg_re | input | 1 | Read strobe; a read of address 0 claims |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | ADDR_W (8) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_re |
| irq_o | output | 1 | Registered interrupt line to the processor |

## Verification
Two gateway events can land on the same clock edge: a claim that takes ownership of a line, and a new rising edge on that same line. The bench provokes this by raising the edge-mode input in exactly the cycle of the claim read. The edge must be kept, not dropped and not merged into the pending bit being cleared. The check completes the line and expects a second claim to return the same identifier. A release is also made while a level-mode input is still high, and the line must then be claimable again.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned PRIO_W  = 2;

    // field positions inside a source word
    localparam int unsigned F_PRIO  = 0;
    localparam int unsigned F_EN    = 2;
    localparam int unsigned F_EDGE  = 3;
    localparam int unsigned F_PEND  = 4;
    localparam int unsigned F_OWNED = 5;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o,
    output logic owned_o
);
    typedef struct packed {
        logic prev;
        logic pend;
        logic owned;
        logic held;
    } gw_t;

    gw_t q, d;
    logic rise;

    always_comb begin
        d      = q;
        rise   = src_i & ~q.prev;
        d.prev = src_i;
        if (claim_i) begin
            d.pend  = 1'b0;
            d.owned = 1'b1;
            d.held  = edge_mode_i & rise;
        end else if (q.owned) begin
            if (complete_i)
                d.owned = 1'b0;
            if (edge_mode_i & rise)
                d.held = 1'b1;
        end else if (edge_mode_i) begin
            if (rise | q.held)
                d.pend = 1'b1;
            d.held = 1'b0;
        end else begin
            if (src_i)
                d.pend = 1'b1;
            d.held = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o  = q.pend;
    assign owned_o = q.owned;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_hub_pkg::*;
#(
    parameter int unsigned NSRC = 79,
    parameter int unsigned ID_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]         pend_i,
    input  logic [NSRC-1:0]         en_i,
    input  prio_t [NSRC-1:0]        prio_i,
    input  prio_t                   thr_i,
    output logic [ID_W-1:0]         win_id_o
);
    prio_t best;

    // strict '>' keeps the first (lowest) identifier on a tie and
    // starting from the threshold enforces the strict threshold rule
    always_comb begin
        best     = thr_i;
        win_id_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (pend_i[k] && en_i[k] && (prio_i[k] > best)) begin
                best     = prio_i[k];
                win_id_o = ID_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NSRC     = 79,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned THR_ADDR = 2 ** (ADDR_W - 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_i,
    input  logic               reg_re,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o
);
    localparam int unsigned ID_W = $clog2(NSRC + 1);

    typedef struct packed {
        prio_t [NSRC-1:0] prio;
        logic  [NSRC-1:0] en;
        logic  [NSRC-1:0] trig_edge;
        prio_t            thr;
        logic             irq;
    } st_t;

    st_t q, d;

    logic [NSRC-1:0] pend_w, owned_w, claim_w, done_w;
    logic [ID_W-1:0] win_id, idx, done_id;
    logic            is_cc, is_thr, is_src, claim_go, done_go;
    logic [5:0]      src_word;

    assign is_cc   = (reg_addr == '0);
    assign is_thr  = (reg_addr == ADDR_W'(THR_ADDR));
    assign is_src  = !is_cc && (reg_addr <= ADDR_W'(NSRC));
    assign idx     = ID_W'(reg_addr - ADDR_W'(1));
    assign done_id = reg_wdata[ID_W-1:0];
    assign claim_go = reg_re && is_cc && (win_id != '0);
    assign done_go  = reg_we && is_cc && (done_id != '0)
                   && (done_id <= ID_W'(NSRC))
                   && (reg_wdata[DATA_W-1:ID_W] == '0);

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_gw
            assign claim_w[g] = claim_go && (win_id == ID_W'(g + 1));
            assign done_w[g]  = done_go  && (done_id == ID_W'(g + 1));
            irq_gateway u_gw (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_i      (src_i[g]),
                .edge_mode_i(q.trig_edge[g]),
                .claim_i    (claim_w[g]),
                .complete_i (done_w[g]),
                .pend_o     (pend_w[g]),
                .owned_o    (owned_w[g])
            );
        end
    endgenerate

    irq_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
        .pend_i  (pend_w),
        .en_i    (q.en),
        .prio_i  (q.prio),
        .thr_i   (q.thr),
        .win_id_o(win_id)
    );

    always_comb begin
        d = q;
        if (reg_we && is_src) begin
            d.prio[idx]      = reg_wdata[F_PRIO +: PRIO_W];
            d.en[idx]        = reg_wdata[F_EN];
            d.trig_edge[idx] = reg_wdata[F_EDGE];
        end
        if (reg_we && is_thr)
            d.thr = reg_wdata[PRIO_W-1:0];
        d.irq = (win_id != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        src_word = {owned_w[idx], pend_w[idx], q.trig_edge[idx],
                    q.en[idx], q.prio[idx]};
        reg_rdata = '0;
        if (is_cc)       reg_rdata = DATA_W'(win_id);
        else if (is_thr) reg_rdata = DATA_W'(q.thr);
        else if (is_src) reg_rdata = DATA_W'(src_word);
    end

    assign irq_o = q.irq;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int unsigned NSRC   = 79,
    parameter int unsigned ID_W   = $clog2(NSRC + 1),
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_re,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_o,
    input logic [NSRC-1:0]   pend_v,
    input logic [NSRC-1:0]   owned_v,
    input logic [NSRC-1:0]   en_v,
    input prio_t [NSRC-1:0]  prio_v,
    input prio_t             thr_v,
    input logic [ID_W-1:0]   win_id
);
    logic [ID_W-1:0] win_idx, taken_q;
    assign win_idx = win_id - ID_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taken_q <= '0;
        else        taken_q <= win_idx;
    end

    // R2
    win_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (en_v[win_idx] && pend_v[win_idx]
                            && (prio_v[win_idx] > thr_v)));

    // R6
    claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == '0 && win_id != '0)
            |=> (owned_v[taken_q] && !pend_v[taken_q]));

    // R6
    pend_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_v & owned_v)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|(pend_v & en_v)) |-> !irq_o);

    // R6
    one_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(owned_v) <= $past($countones(owned_v)) + 1);

    // R7
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(owned_v) < $past($countones(owned_v)))
            |-> $past(reg_we && reg_addr == '0));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_re  (reg_re),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .irq_o   (irq_o),
    .pend_v  (pend_w),
    .owned_v (owned_w),
    .en_v    (q.en),
    .prio_v  (q.prio),
    .thr_v   (q.thr),
    .win_id  (win_id)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
    localparam int NSRC = 79;
    localparam logic [7:0] THR = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic reg_re = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq_o;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq_hub u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_re(reg_re),
                .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
                .reg_rdata(reg_rdata), .irq_o(irq_o));

    typedef struct packed {
        logic [7:0] a;  logic [1:0] pa;
        logic [7:0] b;  logic [1:0] pb;  logic en_b;
        logic [1:0] thr; logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{8'd5,  2'd2, 8'd9,  2'd1, 1'b1, 2'd0, 8'd5},   // R3 priority
        '{8'd5,  2'd1, 8'd9,  2'd3, 1'b1, 2'd0, 8'd9},   // R3 priority
        '{8'd12, 2'd2, 8'd4,  2'd2, 1'b1, 2'd0, 8'd4},   // R3 tie
        '{8'd3,  2'd2, 8'd7,  2'd2, 1'b1, 2'd2, 8'd0},   // R2 equal to threshold
        '{8'd3,  2'd3, 8'd7,  2'd2, 1'b1, 2'd2, 8'd3},   // R2 above threshold
        '{8'd1,  2'd1, 8'd79, 2'd2, 1'b1, 2'd1, 8'd79},  // R2 last id
        '{8'd40, 2'd0, 8'd41, 2'd0, 1'b1, 2'd0, 8'd0},   // R2 priority zero
        '{8'd79, 2'd3, 8'd1,  2'd3, 1'b1, 2'd0, 8'd1},   // R3 tie at ends
        '{8'd20, 2'd1, 8'd21, 2'd3, 1'b0, 2'd0, 8'd20}   // R8 disabled line
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic set_src(input int id, input logic val);
        @(negedge clk);
        src_i[id-1] = val;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        @(negedge clk) check("R1 irq", irq_o, 0);
        rd(8'd0, v);   check("R1 claim", v, 0);
        rd(8'd1, v);   check("R1 src word", v, 0);
        rd(THR, v);    check("R1 threshold", v, 0);

        // vector table
        foreach (VEC[i]) begin
            wr(VEC[i].a, 32'(VEC[i].pa) | 32'h4);
            wr(VEC[i].b, 32'(VEC[i].pb) | (VEC[i].en_b ? 32'h4 : 32'h0));
            wr(THR, 32'(VEC[i].thr));
            @(negedge clk);
            src_i[VEC[i].a-1] = 1'b1; src_i[VEC[i].b-1] = 1'b1;
            idle(3);
            @(negedge clk) check("R2 R9 irq per vector", irq_o, (VEC[i].exp != 0));
            rd(8'd0, v); check("R3 R2 winner per vector", v, VEC[i].exp);
            if (v != 0) wr(8'd0, v);
            @(negedge clk);
            src_i[VEC[i].a-1] = 1'b0; src_i[VEC[i].b-1] = 1'b0;
            wr(THR, 0);
            wr(VEC[i].a, 32'h5);
            wr(VEC[i].b, 32'h5);
            for (int k = 0; k < 4; k++) begin
                rd(8'd0, v);
                if (v != 0) wr(8'd0, v);
                idle(2);
            end
            wr(VEC[i].a, 0);
            wr(VEC[i].b, 0);
        end
        rd(8'd0, v); check("R2 drained", v, 0);

        // edge mode, held edge, wrong release
        wr(8'd10, 32'hE);
        set_src(10, 1'b1); idle(2);
        rd(8'd10, v); check("R5 edge pending", v[4], 1);
        rd(8'd0, v);  check("R5 edge claim", v, 10);
        rd(8'd10, v); check("R6 owned not pending", v[5:4], 2'b10);
        set_src(10, 1'b0); set_src(10, 1'b1); idle(2);
        rd(8'd0, v);  check("R6 owned hidden", v, 0);
        wr(8'd0, 32'd11); idle(1);
        rd(8'd10, v); check("R7 wrong id ignored", v[5], 1);
        wr(8'd0, 32'd10); idle(2);
        rd(8'd0, v);  check("R5 held edge surfaces", v, 10);
        wr(8'd0, 32'd10); idle(2);
        rd(8'd0, v);  check("R5 steady high no repeat", v, 0);
        set_src(10, 1'b0); wr(8'd10, 0);

        // level mode resample
        wr(8'd15, 32'h6);
        set_src(15, 1'b1); idle(2);
        rd(8'd0, v);  check("R4 level claim", v, 15);
        wr(8'd0, 32'd15); idle(2);
        rd(8'd0, v);  check("R4 resample high", v, 15);
        set_src(15, 1'b0);
        wr(8'd0, 32'd15); idle(2);
        rd(8'd0, v);  check("R4 resample low", v, 0);
        wr(8'd15, 0);

        // enable gates forwarding only; registered line
        wr(8'd30, 32'h3);
        set_src(30, 1'b1); idle(3);
        rd(8'd30, v); check("R8 pending while disabled", v[4], 1);
        @(negedge clk) check("R8 irq low while disabled", irq_o, 0);
        rd(8'd0, v);  check("R8 no claim while disabled", v, 0);
        wr(8'd30, 32'h7);
        check("R9 irq not yet", irq_o, 0);
        @(posedge clk); #1;
        check("R9 irq one cycle later", irq_o, 1);
        rd(8'd0, v);  check("R10 claim word", v, 30);
        set_src(30, 1'b0);
        wr(8'd0, 32'd30); wr(8'd30, 0);

        // claim and fresh edge in the same cycle
        wr(8'd50, 32'hD);
        set_src(50, 1'b1); idle(2);
        set_src(50, 1'b0); idle(1);
        @(negedge clk);
        src_i[49] = 1'b1; reg_addr = 8'd0; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1 reg_re = 1'b0;
        check("R5 claim with edge", v, 50);
        wr(8'd0, 32'd50); idle(2);
        rd(8'd0, v);  check("R5 same-cycle edge kept", v, 50);
        wr(8'd0, 32'd50);
        set_src(50, 1'b0); wr(8'd50, 0);
        idle(2);
        @(negedge clk) check("R9 idle at end", irq_o, 0);

        report();
    end
endmodule